// File: doc/BRIEF.md
# Input Voltage Detection Prober

This block decides whether the converter's input rail is present before the regulator is allowed to soft-start. Once the supply power-on-reset indication and the enable are both high, it drives a sparse, low-duty pulse train onto the high-side gate request. If the input rail is present, each probe pulse swings the switch node, and an external comparator reports whether the sensed node lies above its threshold.

The prober passes that comparator bit through a synchronizer and counts every change of the synchronized level, rising or falling. When the count reaches the target (four by default), the block raises a sticky ready flag and stops probing for good. If the comparator never moves, the flag never rises and the pulse train continues forever. Dropping either the power-on-reset indication or the enable shuts both outputs off at once and clears all progress.

Pulse period, pulse width, edge target and synchronizer depth are parameters, with the period and width counted in clock cycles.

Top module: `vin_sense_prober`

## Requirements
- R1: While reset is applied, and after reset until porOk and enable are both high, probeGate and vinReady are 0.
- R2: At the first rising clock edge that samples porOk and enable both high, probing begins, and probeGate is 1 in the cycle that follows that edge.
- R3: While probing, probeGate is 1 for exactly PROBE_WIDTH consecutive cycles and then 0 for the rest of a PROBE_PERIOD-cycle frame, repeating.
- R4: cmpAbove passes through a SYNC_DEPTH-flop synchronizer (2 by default). Each change of level, rising or falling, counts as one edge. vinReady rises at the third rising clock edge after the change that brings the count to EDGE_TARGET (4 by default). Each level must be held across at least two clock edges.
- R5: With fewer than EDGE_TARGET comparator changes, vinReady stays 0 and probing continues.
- R6: While vinReady is 1, probeGate is 0.
- R7: vinReady stays 1 while porOk and enable stay high, and further comparator changes have no effect on either output.
- R8: When porOk or enable goes low, probeGate and vinReady are 0 in that same cycle. The edge count clears, and comparator changes made while inactive are not counted. On return, probing restarts at the start of a frame and EDGE_TARGET fresh changes are needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| porOk | input | 1 | Supply power-on-reset satisfied |
| enable | input | 1 | Block enable |
| cmpAbove | input | 1 | Asynchronous comparator bit, 1 when the sensed node is above threshold |
| probeGate | output | 1 | High-side gate request for probe pulses |
| vinReady | output | 1 | Sticky input-rail-ready flag |

## Verification
The bench targets the following corner cases and the failure each one would expose:
- Exact latency from the decisive comparator change to the ready flag. Counting only rising edges, or adding a stage, moves that rise off the third edge.
- Stopping one change short. A level check or an off-by-one target would declare ready too early.
- Changes made while disabled. If they leaked into the count, ready would come early after re-enable.
- Changes after ready. If the counter were not saturated, or the state not sticky, those changes would either revive probing or drop the flag.
- Probe shape. A frame counter that is off by one would show up as a wrong high run or a wrong period.

// File: rtl/prober_pkg.sv
package prober_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_READY = 2'd2
  } probeState_e;

  typedef struct packed {
    logic clearAll;
    logic runFrame;
    logic countEn;
  } probeStrobe_t;

endpackage

// File: rtl/vin_probe_datapath.sv
module vin_probe_datapath #(
  parameter int PROBE_PERIOD = 5000,
  parameter int PROBE_WIDTH  = 50,
  parameter int EDGE_TARGET  = 4,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    cmpAbove,
  input  prober_pkg::probeStrobe_t strobe,
  output logic                    inPulse,
  output logic                    finalEdge
);

  localparam int PW = (PROBE_PERIOD > 2) ? $clog2(PROBE_PERIOD) : 1;
  localparam int CW = $clog2(EDGE_TARGET + 1);
  localparam logic [PW-1:0] FRAME_LAST = PW'(PROBE_PERIOD - 1);
  localparam logic [PW-1:0] HIGH_LEN   = PW'(PROBE_WIDTH);
  localparam logic [CW-1:0] CNT_LAST   = CW'(EDGE_TARGET - 1);
  localparam logic [CW-1:0] CNT_FULL   = CW'(EDGE_TARGET);

  logic [SYNC_DEPTH-1:0] syncQ;
  logic                  histQ;
  logic                  edgeSeen;
  logic [PW-1:0]         phaseQ;
  logic [CW-1:0]         edgeCnt;

  // synchronizer stages
  for (genvar i = 0; i < SYNC_DEPTH; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[0] <= 1'b0;
        else       syncQ[0] <= cmpAbove;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[i] <= 1'b0;
        else       syncQ[i] <= syncQ[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) histQ <= 1'b0;
    else       histQ <= syncQ[SYNC_DEPTH-1];
  end

  assign edgeSeen = syncQ[SYNC_DEPTH-1] ^ histQ;

  // frame phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ <= '0;
    end else if (strobe.clearAll) begin
      phaseQ <= '0;
    end else if (strobe.runFrame) begin
      if (phaseQ == FRAME_LAST) phaseQ <= '0;
      else                      phaseQ <= phaseQ + 1'b1;
    end
  end

  assign inPulse = (phaseQ < HIGH_LEN);

  // saturating edge counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (strobe.clearAll) begin
      edgeCnt <= '0;
    end else if (strobe.countEn && edgeSeen && (edgeCnt != CNT_FULL)) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign finalEdge = strobe.countEn && edgeSeen && (edgeCnt == CNT_LAST);

endmodule

// File: rtl/vin_probe_ctrl.sv
module vin_probe_ctrl (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     porOk,
  input  logic                     enable,
  input  logic                     inPulse,
  input  logic                     finalEdge,
  output prober_pkg::probeStrobe_t strobe,
  output logic                     probeGate,
  output logic                     vinReady
);
  import prober_pkg::*;

  probeState_e stateQ, stateNext;
  logic        active;

  assign active = porOk & enable;

  always_comb begin
    stateNext = stateQ;
    if (!active) begin
      stateNext = ST_IDLE;
    end else begin
      unique case (stateQ)
        ST_IDLE:  stateNext = ST_PROBE;
        ST_PROBE: if (finalEdge) stateNext = ST_READY;
        ST_READY: stateNext = ST_READY;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobe          = '0;
    strobe.clearAll = (stateQ == ST_IDLE);
    strobe.runFrame = (stateQ == ST_PROBE) && active;
    strobe.countEn  = (stateQ == ST_PROBE) && active;
  end

  assign probeGate = strobe.runFrame && inPulse;
  assign vinReady  = (stateQ == ST_READY) && active;

endmodule

// File: rtl/vin_sense_prober.sv
module vin_sense_prober #(
  parameter int PROBE_PERIOD = 5000,
  parameter int PROBE_WIDTH  = 50,
  parameter int EDGE_TARGET  = 4,
  parameter int SYNC_DEPTH   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic porOk,
  input  logic enable,
  input  logic cmpAbove,
  output logic probeGate,
  output logic vinReady
);

  prober_pkg::probeStrobe_t strobe;
  logic inPulse;
  logic finalEdge;

  vin_probe_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .porOk     (porOk),
    .enable    (enable),
    .inPulse   (inPulse),
    .finalEdge (finalEdge),
    .strobe    (strobe),
    .probeGate (probeGate),
    .vinReady  (vinReady)
  );

  vin_probe_datapath #(
    .PROBE_PERIOD (PROBE_PERIOD),
    .PROBE_WIDTH  (PROBE_WIDTH),
    .EDGE_TARGET  (EDGE_TARGET),
    .SYNC_DEPTH   (SYNC_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cmpAbove  (cmpAbove),
    .strobe    (strobe),
    .inPulse   (inPulse),
    .finalEdge (finalEdge)
  );

endmodule

// File: rtl/vin_probe_checker.sv
module vin_probe_checker #(
  parameter int PROBE_WIDTH = 50,
  parameter int EDGE_TARGET = 4
) (
  input logic clk,
  input logic rstN,
  input logic porOk,
  input logic enable,
  input logic cmpAbove,
  input logic probeGate,
  input logic vinReady
);

  localparam int RW = $clog2(PROBE_WIDTH + 2);
  localparam int CW = $clog2(EDGE_TARGET + 1);

  logic [RW-1:0] highRun;
  logic [CW-1:0] rawChanges;
  logic          cmpPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      highRun    <= '0;
      rawChanges <= '0;
      cmpPrev    <= 1'b0;
    end else begin
      cmpPrev <= cmpAbove;
      if (!probeGate)                     highRun <= '0;
      else if (highRun != {RW{1'b1}})     highRun <= highRun + 1'b1;
      if ((cmpAbove != cmpPrev) && (rawChanges != CW'(EDGE_TARGET)))
        rawChanges <= rawChanges + 1'b1;
    end
  end

  p_width_r3: assert property (@(posedge clk) disable iff (!rstN)
    probeGate |-> (highRun < RW'(PROBE_WIDTH)));

  p_edges_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(vinReady) |-> (rawChanges == CW'(EDGE_TARGET)));

  p_ready_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    vinReady |-> !probeGate);

  p_ready_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (vinReady && porOk && enable) |=> (vinReady || !(porOk && enable)));

  p_inactive_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(porOk && enable) |-> (!probeGate && !vinReady));

endmodule

bind vin_sense_prober vin_probe_checker #(
  .PROBE_WIDTH (PROBE_WIDTH),
  .EDGE_TARGET (EDGE_TARGET)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .porOk     (porOk),
  .enable    (enable),
  .cmpAbove  (cmpAbove),
  .probeGate (probeGate),
  .vinReady  (vinReady)
);

// File: tb/vin_sense_prober_bench.sv
module vin_sense_prober_bench;

  localparam int PERIOD = 40;
  localparam int WIDTH  = 3;
  localparam int TARGET = 4;

  logic clk = 1'b0;
  logic rstN, porOk, enable, cmpAbove;
  logic probeGate, vinReady;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  vin_sense_prober #(
    .PROBE_PERIOD (PERIOD),
    .PROBE_WIDTH  (WIDTH),
    .EDGE_TARGET  (TARGET),
    .SYNC_DEPTH   (2)
  ) u_vin_sense_prober (
    .clk       (clk),
    .rstN      (rstN),
    .porOk     (porOk),
    .enable    (enable),
    .cmpAbove  (cmpAbove),
    .probeGate (probeGate),
    .vinReady  (vinReady)
  );

  function automatic bit expectReady(int changes);
    return changes >= TARGET;
  endfunction

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic flip(int gap);
    cmpAbove = ~cmpAbove;
    cyc(gap);
  endtask

  // count probe highs seen over a window of cycles
  task automatic gateHighs(int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      cyc(1);
      if (probeGate) highs++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hi, lo, highs;
    void'($urandom(32'h1d5e_ed01));
    rstN = 1'b0; porOk = 1'b0; enable = 1'b0; cmpAbove = 1'b0;
    cyc(3);
    chk("R1 gate in reset", probeGate, 0);
    chk("R1 ready in reset", vinReady, 0);
    rstN = 1'b1;
    enable = 1'b1;
    cyc(3);
    chk("R1 gate without por", probeGate, 0);
    chk("R1 ready without por", vinReady, 0);

    // R2: probing starts on the edge sampling porOk & enable
    porOk = 1'b1;
    cyc(1);
    chk("R2 first probe pulse", probeGate, 1);

    // R3: pulse width and frame period
    hi = 1;
    while (probeGate && hi < 4 * PERIOD) begin cyc(1); if (probeGate) hi++; end
    lo = 0;
    while (!probeGate && lo < 4 * PERIOD) begin lo++; cyc(1); end
    chk("R3 pulse width", hi, WIDTH);
    chk("R3 frame period", hi + lo, PERIOD);

    // R5: one change short of the target
    for (int i = 0; i < TARGET - 1; i++) flip(4);
    cyc(4);
    chk("R5 not ready short", vinReady, 0);
    gateHighs(PERIOD, highs);
    chk("R5 probing continues", highs, WIDTH);

    // R4: exact latency of the decisive change
    cmpAbove = ~cmpAbove;
    cyc(2);
    chk("R4 ready not before third edge", vinReady, 0);
    cyc(1);
    chk("R4 ready on third edge", vinReady, 1);

    // R6: no probes while ready
    gateHighs(PERIOD + 5, highs);
    chk("R6 gate quiet when ready", highs, 0);

    // R7: extra changes ignored, flag sticky
    for (int i = 0; i < 3; i++) flip(4);
    cyc(4);
    chk("R7 ready sticky", vinReady, 1);
    gateHighs(PERIOD, highs);
    chk("R7 no probe revival", highs, 0);

    // R8: disable drops outputs at once
    @(negedge clk);
    enable = 1'b0;
    #1;
    chk("R8 ready off same cycle", vinReady, 0);
    chk("R8 gate off same cycle", probeGate, 0);
    flip(4);
    flip(4);
    cyc(5);
    enable = 1'b1;
    cyc(1);
    chk("R8 probe restarts at frame start", probeGate, 1);
    for (int i = 0; i < TARGET - 1; i++) flip(4);
    cyc(4);
    chk("R8 fresh count needed", vinReady, 0);
    flip(4);
    chk("R8 ready after fresh target", vinReady, 1);

    // R8: por loss
    porOk = 1'b0;
    #1;
    chk("R8 ready off on por loss", vinReady, 0);
    cyc(2);
    porOk = 1'b1;
    cyc(1);
    chk("R8 probing after por return", probeGate, 1);

    // random trials
    for (int t = 0; t < 24; t++) begin
      int n;
      enable = 1'b0;
      cyc(4);
      enable = 1'b1;
      cyc(2);
      n = $urandom_range(0, 7);
      for (int k = 0; k < n; k++) flip($urandom_range(3, 10));
      cyc(4);
      chk(expectReady(n) ? "R4 random ready" : "R5 random not ready",
          vinReady, expectReady(n));
      gateHighs(PERIOD, highs);
      chk(expectReady(n) ? "R6 random quiet" : "R3 random probing",
          highs, expectReady(n) ? 0 : WIDTH);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule